// File: doc/BRIEF.md
# Active-Halt Power Mode Sequencer

This block decides how a small processor core sleeps and wakes. When the core issues a halt strobe, the block looks at an oscillator-interrupt-enable bit and picks one of two sleep depths. In active halt the main oscillator and the real-time-clock counter keep running, so a timed wake-up stays possible. In plain halt every clock enable is dropped. The block drives the four clock enables (CPU, peripherals, main oscillator, RTC counter). It also produces a one-cycle wake strobe, a vector select and a strobe that forces the interrupt mask bits. While in active halt it gives a watchdog-reset suppress signal.

The wake path depends on the source and on the sleep depth. An interrupt wakes active halt at once, with no settling time. A reset request always waits 256 or 4096 cycles, chosen by an option bit, and then releases the reset vector. An exit from plain halt also waits for the stabilisation delay. After an RTC wake the block runs a stabilisation window of the selected length. If software clears the enable bit inside that window, the CPU clock is gated again until the window ends.

Top module: `ahs_seq`

## Requirements
- R1: A halt strobe in the run state enters active halt when the enable bit is 1, and plain halt when it is 0. The clock enables change on the next clock edge. Halt strobes seen while already in plain halt have no effect.
- R2: In active halt the oscillator and RTC enables are 1 and the CPU and peripheral enables are 0. The watchdog-suppress output is 1 only in active halt, and only while the watchdog-active input is 1.
- R3: In active halt, an external or RTC interrupt raises the CPU enable on the next edge. The vector select reads 0 (interrupt vector) and no delay is inserted.
- R4: A reset request holds the CPU enable low for exactly N cycles and then raises it with the vector select at 1 (reset vector). N is 256 when the option bit is 0 and 4096 when it is 1.
- R5: The interrupt-mask force strobe is high for exactly the first cycle of active halt. An interrupt already high when the halt strobe arrives wakes the block in the cycle after that first cycle.
- R6: A reset request takes priority over any interrupt in the same cycle. The CPU enable is low on the next edge and the exit follows R4.
- R7: In plain halt all four enables are 0 and an RTC interrupt is ignored. An external interrupt leaves plain halt after the N-cycle delay, with the vector select at 0.
- R8: After an RTC wake, clearing the enable bit before N cycles have passed since the wake drops the CPU and peripheral enables, while the oscillator stays enabled. The CPU enable rises again exactly N cycles after the wake, with a wake strobe and the vector select at 0.
- R9: After an RTC wake, if the enable bit stays set, the CPU enable stays high through the whole window and no further wake strobe is issued.
- R10: The wake strobe is a single-cycle pulse, high exactly in the cycle the CPU enable rises. After the synchronous reset all enables are 1, the vector select is 1, and neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Halt instruction strobe |
| oie_i | input | 1 | Oscillator interrupt enable bit |
| ext_irq_i | input | 1 | External interrupt |
| rtc_irq_i | input | 1 | Real-time-clock interrupt |
| rst_req_i | input | 1 | Reset request |
| wdg_active_i | input | 1 | Watchdog running flag |
| long_dly_i | input | 1 | Delay option: 0 gives 256 cycles, 1 gives 4096 cycles |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_clk_en_o | output | 1 | Main oscillator enable |
| rtc_clk_en_o | output | 1 | RTC counter clock enable |
| wake_o | output | 1 | One-cycle wake strobe |
| vec_sel_o | output | 1 | 1 = reset vector, 0 = interrupt vector |
| imask_force_o | output | 1 | Strobe forcing interrupt mask bits to 10 |
| wdg_rst_mask_o | output | 1 | Suppresses watchdog reset |

## Verification
The hardest state to reach is the gated stretch after an RTC wake. The stimulus has to wake active halt with an RTC interrupt, let the window run for a known number of cycles with the enable bit set, and then clear the bit. The bench counts gated cycles and expects the exact remainder of the window. A second hard case is an interrupt that is already pending when the halt strobe arrives: the stimulus holds the interrupt high across the strobe, so the mask-force strobe and the immediate wake fall on consecutive cycles.

// File: rtl/ahs_pkg.sv
package ahs_pkg;

    typedef enum logic [2:0] {
        S_RUN,
        S_AHALT,
        S_HALT,
        S_STAB,
        S_RTCWIN,
        S_RTCGATE
    } ahs_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic rtc;
    } clk_en_t;

    function automatic clk_en_t state_clocks(ahs_state_e s);
        clk_en_t c;
        case (s)
            S_RUN, S_RTCWIN: c = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, rtc: 1'b1};
            S_AHALT:         c = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, rtc: 1'b1};
            S_STAB,
            S_RTCGATE:       c = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, rtc: 1'b0};
            default:         c = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, rtc: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ahs_dly_cnt.sv
module ahs_dly_cnt #(
    parameter int CNT_W     = 12,
    parameter int SHORT_DLY = 256,
    parameter int LONG_DLY  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic long_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_DLY - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_DLY - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= long_i ? LONG_LD : SHORT_LD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !zero_o);  // R4

endmodule

// File: rtl/ahs_fsm.sv
module ahs_fsm
    import ahs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_i,
    input  logic       oie_i,
    input  logic       ext_irq_i,
    input  logic       rtc_irq_i,
    input  logic       rst_req_i,
    input  logic       cnt_zero_i,
    output ahs_state_e state_o,
    output logic       load_o,
    output logic       vec_o,
    output logic       imask_o
);
    ahs_state_e state_q, state_n;
    logic       cause_q, cause_n;
    logic       vec_q, vec_n;
    logic       imask_q;

    always_comb begin
        state_n = state_q;
        cause_n = cause_q;
        vec_n   = vec_q;
        load_o  = 1'b0;
        if (rst_req_i) begin
            state_n = S_STAB;
            cause_n = 1'b1;
            load_o  = 1'b1;
        end else begin
            case (state_q)
                S_RUN: begin
                    if (halt_i) state_n = oie_i ? S_AHALT : S_HALT;
                end
                S_AHALT: begin
                    if (rtc_irq_i) begin
                        state_n = S_RTCWIN;
                        load_o  = 1'b1;
                        vec_n   = 1'b0;
                    end else if (ext_irq_i) begin
                        state_n = S_RUN;
                        vec_n   = 1'b0;
                    end
                end
                S_HALT: begin
                    if (ext_irq_i) begin
                        state_n = S_STAB;
                        cause_n = 1'b0;
                        load_o  = 1'b1;
                    end
                end
                S_STAB: begin
                    if (cnt_zero_i) begin
                        state_n = S_RUN;
                        vec_n   = cause_q;
                    end
                end
                S_RTCWIN: begin
                    if (cnt_zero_i)   state_n = S_RUN;
                    else if (!oie_i)  state_n = S_RTCGATE;
                    else if (halt_i)  state_n = S_AHALT;
                end
                S_RTCGATE: begin
                    if (cnt_zero_i) state_n = S_RUN;
                end
                default: state_n = S_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_RUN;
            cause_q <= 1'b1;
            vec_q   <= 1'b1;
            imask_q <= 1'b0;
        end else begin
            state_q <= state_n;
            cause_q <= cause_n;
            vec_q   <= vec_n;
            imask_q <= (state_n == S_AHALT) && (state_q != S_AHALT);
        end
    end

    assign state_o = state_q;
    assign vec_o   = vec_q;
    assign imask_o = imask_q;

    AST_STAB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_STAB && !cnt_zero_i && !rst_req_i) |=> state_q == S_STAB);  // R4
    AST_HALT_RTC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HALT && !ext_irq_i && !rst_req_i) |=> state_q == S_HALT);  // R7
    AST_GATE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RTCGATE && !rst_req_i && !cnt_zero_i) |=> state_q == S_RTCGATE);  // R8

endmodule

// File: rtl/ahs_seq.sv
module ahs_seq
    import ahs_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int SHORT_DLY = 256,
    parameter int LONG_DLY  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_i,
    input  logic oie_i,
    input  logic ext_irq_i,
    input  logic rtc_irq_i,
    input  logic rst_req_i,
    input  logic wdg_active_i,
    input  logic long_dly_i,
    output logic cpu_clk_en_o,
    output logic per_clk_en_o,
    output logic osc_clk_en_o,
    output logic rtc_clk_en_o,
    output logic wake_o,
    output logic vec_sel_o,
    output logic imask_force_o,
    output logic wdg_rst_mask_o
);
    ahs_state_e st;
    logic       load, cnt_zero, cpu_q;
    clk_en_t    en;

    ahs_dly_cnt #(.CNT_W(CNT_W), .SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .long_i (long_dly_i),
        .zero_o (cnt_zero)
    );

    ahs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .halt_i     (halt_i),
        .oie_i      (oie_i),
        .ext_irq_i  (ext_irq_i),
        .rtc_irq_i  (rtc_irq_i),
        .rst_req_i  (rst_req_i),
        .cnt_zero_i (cnt_zero),
        .state_o    (st),
        .load_o     (load),
        .vec_o      (vec_sel_o),
        .imask_o    (imask_force_o)
    );

    assign en = state_clocks(st);

    always_ff @(posedge clk) begin
        if (rst) cpu_q <= 1'b1;
        else     cpu_q <= en.cpu;
    end

    assign cpu_clk_en_o   = en.cpu;
    assign per_clk_en_o   = en.per;
    assign osc_clk_en_o   = en.osc;
    assign rtc_clk_en_o   = en.rtc;
    assign wake_o         = en.cpu & ~cpu_q;
    assign wdg_rst_mask_o = (st == S_AHALT) & wdg_active_i;

    AST_AHALT_CLOCKS: assert property (@(posedge clk) disable iff (rst)
        wdg_rst_mask_o |-> (osc_clk_en_o && rtc_clk_en_o && !cpu_clk_en_o && !per_clk_en_o));  // R2
    AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (rst)
        (st == S_AHALT && (ext_irq_i || rtc_irq_i) && !rst_req_i) |=> (cpu_clk_en_o && !vec_sel_o));  // R3
    AST_RST_FIRST: assert property (@(posedge clk) disable iff (rst)
        rst_req_i |=> !cpu_clk_en_o);  // R6
    AST_IMASK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        imask_force_o |-> (osc_clk_en_o && !cpu_clk_en_o));  // R5
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o);  // R10

endmodule

// File: tb/ahs_seq_bench.sv
`timescale 1ns/1ps
module ahs_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt = 0, oie = 1, ext = 0, rtc = 0, rreq = 0, wdg = 1, lng = 0;
    logic cpu, per, osc, rtce, wake, vec, imask, wmask;
    int   errors = 0;
    int   checks = 0;

    always #4 clk = ~clk;

    ahs_seq u_ahs_seq (
        .clk(clk), .rst(rst), .halt_i(halt), .oie_i(oie), .ext_irq_i(ext),
        .rtc_irq_i(rtc), .rst_req_i(rreq), .wdg_active_i(wdg), .long_dly_i(lng),
        .cpu_clk_en_o(cpu), .per_clk_en_o(per), .osc_clk_en_o(osc),
        .rtc_clk_en_o(rtce), .wake_o(wake), .vec_sel_o(vec),
        .imask_force_o(imask), .wdg_rst_mask_o(wmask)
    );

    // inputs {halt,oie,ext,rtc,rreq,long,wdg} | expected {cpu,per,osc,rtc,wake,vec,imask,wmask}
    localparam int NV = 9;
    localparam logic [14:0] VEC [NV] = '{
        15'b0100001_11110100,  // R10 idle after reset
        15'b1100001_00110111,  // R1 enter active halt
        15'b0100001_00110101,  // R2 stay in active halt
        15'b0110001_11111000,  // R3 external interrupt wake
        15'b0100001_11110000,  // R10 wake strobe gone
        15'b1000001_00000000,  // R1 enter plain halt
        15'b0001001_00000000,  // R7 rtc ignored
        15'b1100001_00000000,  // R7 halt strobe ignored
        15'b0000000_00000000   // R2 no mask in plain halt
    };
    string vreq [NV] = '{"R10", "R1", "R2", "R3", "R10", "R1", "R7", "R7", "R2"};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic count_gated(string req, int exp, logic exp_vec);
        int n = 0;
        while (!cpu && n < 10000) begin
            n++;
            tick();
        end
        chk(req, "gated cycles", n, exp);
        chk(req, "wake at rise", int'(wake), 1);
        chk(req, "vector select", int'(vec), int'(exp_vec));
    endtask

    task automatic to_ahalt();
        halt = 1; oie = 1; tick(); halt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        chk("R10", "reset cpu", int'(cpu), 1);
        chk("R10", "reset vec", int'(vec), 1);
        chk("R10", "reset imask", int'(imask), 0);

        for (int i = 0; i < NV; i++) begin
            {halt, oie, ext, rtc, rreq, lng, wdg} = VEC[i][14:8];
            tick();
            chk(vreq[i], $sformatf("vector %0d outputs", i),
                int'({cpu, per, osc, rtce, wake, vec, imask, wmask}), int'(VEC[i][7:0]));
        end
        {halt, oie, ext, rtc, rreq, lng, wdg} = 7'b0100001;

        // R7: external interrupt out of plain halt pays the short delay
        ext = 1; tick(); ext = 0;
        count_gated("R7", 256, 1'b0);

        // R4: reset request from active halt with the long delay
        to_ahalt(); lng = 1;
        rreq = 1; tick(); rreq = 0;
        count_gated("R4", 4096, 1'b1);
        lng = 0;

        // R6: reset request and interrupt in the same cycle
        to_ahalt();
        rreq = 1; ext = 1; tick(); rreq = 0; ext = 0;
        chk("R6", "cpu gated", int'(cpu), 0);
        count_gated("R6", 256, 1'b1);

        // R5: interrupt pending at entry
        halt = 1; oie = 1; ext = 1; tick(); halt = 0;
        chk("R5", "mask strobe", int'(imask), 1);
        chk("R5", "cpu in entry", int'(cpu), 0);
        tick();
        chk("R5", "immediate wake", int'(wake), 1);
        chk("R5", "mask strobe once", int'(imask), 0);
        ext = 0; tick();

        // R9: rtc wake with enable kept set
        to_ahalt();
        rtc = 1; tick(); rtc = 0;
        chk("R3", "rtc wake strobe", int'(wake), 1);
        chk("R3", "rtc vector", int'(vec), 0);
        begin
            int wk = 0, off = 0;
            for (int k = 0; k < 300; k++) begin
                tick();
                wk += int'(wake);
                off += int'(!cpu);
            end
            chk("R9", "extra wakes", wk, 0);
            chk("R9", "gated cycles", off, 0);
        end

        // R8: enable cleared 11 cycles into the window
        to_ahalt();
        rtc = 1; tick(); rtc = 0;
        repeat (10) tick();
        oie = 0; tick();
        chk("R8", "cpu gated", int'(cpu), 0);
        chk("R8", "per gated", int'(per), 0);
        chk("R8", "osc kept", int'(osc), 1);
        count_gated("R8", 245, 1'b0);
        oie = 1; tick();

        // R2: watchdog suppress follows watchdog-active in active halt
        wdg = 0; to_ahalt();
        chk("R2", "mask with wdg off", int'(wmask), 0);
        wdg = 1; #1;
        chk("R2", "mask with wdg on", int'(wmask), 1);
        ext = 1; tick(); ext = 0;

        // R10: synchronous reset from active halt
        to_ahalt();
        rst = 1; tick(); rst = 0;
        chk("R10", "cpu after reset", int'(cpu), 1);
        chk("R10", "vec after reset", int'(vec), 1);
        chk("R10", "no wake after reset", int'(wake), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule